// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Four-Modulus Prescaler

This block is a clocked digital model of the feedback divider used in a fractional-N frequency synthesizer. It counts cycles of its input clock, which stands in for the oscillator being divided. It emits one single-cycle pulse each time a division completes. Each division lasts either N or N+1 input cycles. The choice between the two is made by a first-order fractional accumulator, so that the long-run ratio is N + F/Q. The denominator Q is either 15 or 16.

Inside, the integer ratio is built the way a swallow-counter synthesizer builds it. A prescaler counts one of four moduli: P, P+1, P+4 or P+5. Two short swallow counters choose the modulus for each prescaler cycle. A main counter sets how many prescaler cycles make up one division. The high band uses P = 16 and the low band uses P = 8. Each band has its own legal range for the integer ratio. A request outside that range is clamped and flagged.

Smaller denominators are reached by scaling the numerator. For example, a ratio of 2/5 is requested as F = 6 with Q = 15, and 1/8 is requested as F = 2 with Q = 16. The accumulator modulus never changes for this.

Top module: `fnd_top`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0. After `rst_n` rises, the first division starts on the first rising clock edge. `div_pulse` is first seen high just after rising edge number 1+N0, counted from the release of reset, where N0 is the length of that first division.
- R2: `div_pulse` is high for exactly one cycle per division. The distance between two consecutive pulses equals the length of the division that lies between them.
- R3: With `band_hi` = 1, the prescaler base is P = 16. The integer request is decomposed as N = 16·B + 4·C + A, with A and C each in 0..3. Every integer N from 80 to 32767 is produced exactly.
- R4: With `band_hi` = 0, the prescaler base is P = 8. The integer request is decomposed as N = 8·B + 4·C + A, with C in 0..1 and A in 0..3. Every integer N from 40 to 16383 is produced exactly.
- R5: An integer request below the band minimum is replaced by the band minimum, and one above the band maximum is replaced by the band maximum. While the request is out of range, `range_err` is 1. `range_err` is combinational from the inputs.
- R6: `den_is15` = 1 selects Q = 15 and `den_is15` = 0 selects Q = 16. A numerator F ≥ Q, which can only be F = 15 with Q = 15, is replaced by Q−1 and sets `range_err`.
- R7: The accumulator starts at 0 on reset. At the start of every division, F is added to it. If the sum is at least Q, Q is subtracted from it and that division lasts N+1 cycles; otherwise it lasts N cycles.
- R8: Over any Q consecutive divisions with constant inputs, the total number of input cycles is exactly Q·N + F.
- R9: The inputs are sampled only on the edge where a division begins. A change made during a division does not alter that division; it takes effect from the next division.
- R10: Every prescaler cycle lasts P, P+1, P+4 or P+5 input cycles. The main counter never holds fewer remaining cycles than either swallow counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| band_hi | input | 1 | 1: prescaler base 16; 0: prescaler base 8 |
| den_is15 | input | 1 | 1: accumulator modulus 15; 0: modulus 16 |
| n_req | input | 15 | Requested integer divide ratio |
| frac_num | input | 4 | Fractional numerator F |
| div_pulse | output | 1 | One-cycle pulse at the end of each division |
| range_err | output | 1 | Request was clamped (N out of band range, or F ≥ Q) |

## Verification
The hardest situation to reach is a division of 32768 cycles in the high band. That length needs a main count of 2048, one past the largest integer request. It only occurs when a carry from the accumulator lands on N = 32767. The stimulus sets N = 32767 with F = 15 and Q = 16. The first division then carries no extra cycle, and the second division is forced to carry one, so the second interval must measure 32768. Every other vector runs the accumulator over a full period of Q divisions and compares the total cycle count against Q·N + F.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int NREQ_W = 15;
  localparam int FRAC_W = 4;
  localparam int NEFF_W = NREQ_W + 1;
  localparam int B_W    = 12;
  localparam int PC_W   = 5;
  localparam int Q_W    = FRAC_W + 1;

  localparam int HI_BASE = 16;
  localparam int LO_BASE = 8;
  localparam int HI_NMIN = 80;
  localparam int HI_NMAX = 32767;
  localparam int LO_NMIN = 40;
  localparam int LO_NMAX = 16383;
  localparam int SWAL_STEP = 4;

  typedef struct packed {
    logic [B_W-1:0] b;
    logic [1:0]     c;
    logic [1:0]     a;
  } split_t;

  function automatic logic [NEFF_W-1:0] band_min(input logic hi);
    return hi ? NEFF_W'(HI_NMIN) : NEFF_W'(LO_NMIN);
  endfunction

  function automatic logic [NEFF_W-1:0] band_max(input logic hi);
    return hi ? NEFF_W'(HI_NMAX) : NEFF_W'(LO_NMAX);
  endfunction

  function automatic logic n_bad(input logic [NREQ_W-1:0] n, input logic hi);
    logic [NEFF_W-1:0] v;
    v = NEFF_W'(n);
    return (v < band_min(hi)) || (v > band_max(hi));
  endfunction

  function automatic logic [NEFF_W-1:0] clamp_n(input logic [NREQ_W-1:0] n, input logic hi);
    logic [NEFF_W-1:0] v;
    v = NEFF_W'(n);
    if (v < band_min(hi)) return band_min(hi);
    if (v > band_max(hi)) return band_max(hi);
    return v;
  endfunction

  function automatic logic [Q_W-1:0] den_of(input logic is15);
    return is15 ? Q_W'(15) : Q_W'(16);
  endfunction

  // N = P*B + 4*C + A
  function automatic split_t split_n(input logic [NEFF_W-1:0] n, input logic hi);
    split_t s;
    if (hi) begin
      s.b = B_W'(n >> 4);
      s.c = n[3:2];
      s.a = n[1:0];
    end else begin
      s.b = B_W'(n >> 3);
      s.c = {1'b0, n[2]};
      s.a = n[1:0];
    end
    return s;
  endfunction

  function automatic logic [PC_W-1:0] modulus(input logic hi, input logic a_on, input logic c_on);
    logic [PC_W-1:0] m;
    m = hi ? PC_W'(HI_BASE) : PC_W'(LO_BASE);
    m = m + PC_W'(a_on);
    if (c_on) m = m + PC_W'(SWAL_STEP);
    return m;
  endfunction

  function automatic logic legal_mod(input logic hi, input logic [PC_W-1:0] m);
    logic [PC_W-1:0] p;
    p = hi ? PC_W'(HI_BASE) : PC_W'(LO_BASE);
    return (m == p) || (m == p + PC_W'(1)) ||
           (m == p + PC_W'(SWAL_STEP)) || (m == p + PC_W'(SWAL_STEP + 1));
  endfunction
endpackage

// File: rtl/fnd_ratio_sel.sv
module fnd_ratio_sel
  import fnd_pkg::*;
#(
  parameter int NW = NREQ_W,
  parameter int FW = FRAC_W
) (
  input  logic              band_hi,
  input  logic              den_is15,
  input  logic [NW-1:0]     n_req,
  input  logic [FW-1:0]     frac_num,
  output logic [NW:0]       n_eff,
  output logic [FW-1:0]     f_eff,
  output logic [FW:0]       q_sel,
  output logic              err
);
  logic f_big;
  logic n_out;

  always_comb begin
    q_sel = den_of(den_is15);
    f_big = ({1'b0, frac_num} >= q_sel);
    f_eff = f_big ? FW'(q_sel - 1'b1) : frac_num;
    n_out = n_bad(n_req, band_hi);
    n_eff = clamp_n(n_req, band_hi);
    err   = n_out | f_big;
  end
endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc
  import fnd_pkg::*;
#(
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [FW-1:0] f_eff,
  input  logic [FW:0]   q_sel,
  output logic          carry
);
  logic [FW-1:0] acc;
  logic [FW:0]   sum;
  logic [FW:0]   nxt;

  always_comb begin
    sum   = {1'b0, acc} + {1'b0, f_eff};
    carry = (sum >= q_sel);
    nxt   = carry ? (sum - q_sel) : sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (step)  acc <= nxt[FW-1:0];
  end
endmodule

// File: rtl/fnd_swallow_ctr.sv
module fnd_swallow_ctr
  import fnd_pkg::*;
#(
  parameter int NW = NEFF_W,
  parameter int BW = B_W,
  parameter int PW = PC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          band_hi,
  input  logic [NW-1:0] n_load,
  output logic          div_end,
  output logic [PW-1:0] cur_mod,
  output logic          hi_q,
  output logic [PW-1:0] pc,
  output logic [BW-1:0] b_left,
  output logic [1:0]    a_left,
  output logic [1:0]    c_left
);
  split_t        ld;
  logic [1:0]    a_dec;
  logic [1:0]    c_dec;
  logic [PW-1:0] mod_wrap;
  logic [PW-1:0] mod_load;
  logic          pre_wrap;

  always_comb begin
    pre_wrap = (pc == '0);
    div_end  = pre_wrap && (b_left == BW'(1));
    a_dec    = (a_left != 2'd0) ? a_left - 2'd1 : 2'd0;
    c_dec    = (c_left != 2'd0) ? c_left - 2'd1 : 2'd0;
    ld       = split_n(n_load, band_hi);
    mod_wrap = modulus(hi_q, a_dec != 2'd0, c_dec != 2'd0);
    mod_load = modulus(band_hi, ld.a != 2'd0, ld.c != 2'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      b_left  <= BW'(1);
      a_left  <= 2'd0;
      c_left  <= 2'd0;
      hi_q    <= 1'b1;
      cur_mod <= PW'(HI_BASE);
    end else if (div_end) begin
      b_left  <= ld.b;
      a_left  <= ld.a;
      c_left  <= ld.c;
      hi_q    <= band_hi;
      pc      <= mod_load - PW'(1);
      cur_mod <= mod_load;
    end else if (pre_wrap) begin
      b_left  <= b_left - BW'(1);
      a_left  <= a_dec;
      c_left  <= c_dec;
      pc      <= mod_wrap - PW'(1);
      cur_mod <= mod_wrap;
    end else begin
      pc      <= pc - PW'(1);
    end
  end
endmodule

// File: rtl/fnd_top.sv
module fnd_top
  import fnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              band_hi,
  input  logic              den_is15,
  input  logic [NREQ_W-1:0] n_req,
  input  logic [FRAC_W-1:0] frac_num,
  output logic              div_pulse,
  output logic              range_err
);
  logic [NEFF_W-1:0] n_eff;
  logic [NEFF_W-1:0] n_load;
  logic [FRAC_W-1:0] f_eff;
  logic [Q_W-1:0]    q_sel;
  logic              carry;
  logic              sw_end;
  logic [PC_W-1:0]   sw_mod;
  logic              sw_hi;
  logic [PC_W-1:0]   sw_pc;
  logic [B_W-1:0]    sw_b;
  logic [1:0]        sw_a;
  logic [1:0]        sw_c;
  logic              primed;

  fnd_ratio_sel u_sel (
    .band_hi (band_hi),
    .den_is15(den_is15),
    .n_req   (n_req),
    .frac_num(frac_num),
    .n_eff   (n_eff),
    .f_eff   (f_eff),
    .q_sel   (q_sel),
    .err     (range_err)
  );

  fnd_frac_acc u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .step (sw_end),
    .f_eff(f_eff),
    .q_sel(q_sel),
    .carry(carry)
  );

  assign n_load = n_eff + NEFF_W'(carry);

  fnd_swallow_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .band_hi(band_hi),
    .n_load (n_load),
    .div_end(sw_end),
    .cur_mod(sw_mod),
    .hi_q   (sw_hi),
    .pc     (sw_pc),
    .b_left (sw_b),
    .a_left (sw_a),
    .c_left (sw_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      primed    <= 1'b1;
      div_pulse <= sw_end & primed;
    end
  end
endmodule

// File: rtl/fnd_checker.sv
module fnd_checker
  import fnd_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            div_pulse,
  input logic            div_end,
  input logic [PC_W-1:0] cur_mod,
  input logic            hi_q,
  input logic [PC_W-1:0] pc,
  input logic [B_W-1:0]  b_left,
  input logic [1:0]      a_left,
  input logic [1:0]      c_left
);
  a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  a_r1_pulse_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(div_end));

  a_r10_legal_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    legal_mod(hi_q, cur_mod));

  a_r10_main_covers_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (b_left >= B_W'(a_left)) && (b_left >= B_W'(c_left)));

  a_r9_main_held_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_end && pc != '0) |=> $stable(b_left));
endmodule

bind fnd_top fnd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .div_pulse(div_pulse),
  .div_end  (sw_end),
  .cur_mod  (sw_mod),
  .hi_q     (sw_hi),
  .pc       (sw_pc),
  .b_left   (sw_b),
  .a_left   (sw_a),
  .c_left   (sw_c)
);

// File: tb/tb_fnd_top.sv
module tb_fnd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        band_hi = 1'b1;
  logic        den_is15 = 1'b0;
  logic [14:0] n_req = 15'd100;
  logic [3:0]  frac_num = 4'd0;
  logic        div_pulse;
  logic        range_err;

  int nvec = 0;
  int nerr = 0;
  int acc_m = 0;

  always #2 clk = ~clk;

  fnd_top dut (
    .clk(clk), .rst_n(rst_n), .band_hi(band_hi), .den_is15(den_is15),
    .n_req(n_req), .frac_num(frac_num), .div_pulse(div_pulse), .range_err(range_err)
  );

  typedef struct packed {
    logic        hi;
    logic        d15;
    logic [14:0] n;
    logic [3:0]  f;
    logic [15:0] en;
    logic [3:0]  ef;
    logic        err;
    logic [5:0]  niv;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 15'd100,   4'd0,  16'd100,   4'd0,  1'b0, 6'd16},
    '{1'b1, 1'b0, 15'd1000,  4'd5,  16'd1000,  4'd5,  1'b0, 6'd16},
    '{1'b1, 1'b1, 15'd95,    4'd7,  16'd95,    4'd7,  1'b0, 6'd15},
    '{1'b0, 1'b0, 15'd40,    4'd8,  16'd40,    4'd8,  1'b0, 6'd16},
    '{1'b0, 1'b1, 15'd47,    4'd3,  16'd47,    4'd3,  1'b0, 6'd15},
    '{1'b1, 1'b0, 15'd79,    4'd1,  16'd80,    4'd1,  1'b1, 6'd16},
    '{1'b1, 1'b0, 15'd0,     4'd0,  16'd80,    4'd0,  1'b1, 6'd4},
    '{1'b1, 1'b1, 15'd200,   4'd15, 16'd200,   4'd14, 1'b1, 6'd15},
    '{1'b0, 1'b0, 15'd20000, 4'd4,  16'd16383, 4'd4,  1'b1, 6'd1},
    '{1'b1, 1'b0, 15'd32767, 4'd15, 16'd32767, 4'd15, 1'b0, 6'd1},
    '{1'b0, 1'b1, 15'd300,   4'd10, 16'd300,   4'd10, 1'b0, 6'd15}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // accumulator model: returns extra cycle for the next division
  function automatic int model_step(input int f, input int q);
    int s;
    s = acc_m + f;
    if (s >= q) begin
      acc_m = s - q;
      return 1;
    end
    acc_m = s;
    return 0;
  endfunction

  // counts rising edges until div_pulse is seen high; dbl flags a pulse on the first edge
  task automatic wait_pulse(output int cnt, output bit dbl);
    cnt = 0;
    dbl = 1'b0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (cnt == 1 && div_pulse) dbl = 1'b1;
    end while ((!div_pulse || (cnt == 1 && dbl)) && cnt < 40000);
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R1 pulse low in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    acc_m = 0;
  endtask

  initial begin
    #(4 * 195000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int cnt, q, c, total, expd;
    bit dbl;

    for (int v = 0; v < NV; v++) begin
      band_hi  = VT[v].hi;
      den_is15 = VT[v].d15;
      n_req    = VT[v].n;
      frac_num = VT[v].f;
      q = VT[v].d15 ? 15 : 16;
      restart();
      chk(range_err == VT[v].err, "R5/R6 range_err", int'(range_err), int'(VT[v].err));
      c = model_step(int'(VT[v].ef), q);
      wait_pulse(cnt, dbl);
      chk(cnt == 1 + int'(VT[v].en) + c, "R1 first pulse edge", cnt, 1 + int'(VT[v].en) + c);
      total = 0;
      for (int i = 0; i < int'(VT[v].niv); i++) begin
        c = model_step(int'(VT[v].ef), q);
        expd = int'(VT[v].en) + c;
        wait_pulse(cnt, dbl);
        chk(!dbl, "R2 single-cycle pulse", int'(dbl), 0);
        if (VT[v].hi)
          chk(cnt == expd, "R3/R7/R10 high band interval", cnt, expd);
        else
          chk(cnt == expd, "R4/R7/R10 low band interval", cnt, expd);
        total += cnt;
      end
      if (int'(VT[v].niv) == q)
        chk(total == q * int'(VT[v].en) + int'(VT[v].ef), "R8 average over Q",
            total, q * int'(VT[v].en) + int'(VT[v].ef));
    end

    // R9: a mid-division change waits for the next boundary
    band_hi = 1'b1; den_is15 = 1'b0; n_req = 15'd200; frac_num = 4'd0;
    restart();
    wait_pulse(cnt, dbl);
    chk(cnt == 201, "R1 first pulse edge", cnt, 201);
    repeat (10) @(negedge clk);
    n_req = 15'd300;
    wait_pulse(cnt, dbl);
    chk(cnt == 190, "R9 current division unchanged", cnt, 190);
    wait_pulse(cnt, dbl);
    chk(cnt == 300, "R9 new ratio from next division", cnt, 300);

    // R5: band limits on the error flag
    @(negedge clk);
    band_hi = 1'b1; n_req = 15'd50; #1;
    chk(range_err == 1'b1, "R5 high band below min", int'(range_err), 1);
    band_hi = 1'b0; #1;
    chk(range_err == 1'b0, "R5 low band in range", int'(range_err), 0);
    n_req = 15'd16383; #1;
    chk(range_err == 1'b0, "R5 low band max", int'(range_err), 0);
    n_req = 15'd16384; #1;
    chk(range_err == 1'b1, "R5 low band above max", int'(range_err), 1);
    den_is15 = 1'b0; frac_num = 4'd15; n_req = 15'd100; #1;
    chk(range_err == 1'b0, "R6 F=15 legal with Q=16", int'(range_err), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule